// File: doc/BRIEF.md
# Command-Byte Host Access Decoder

This block sits behind a byte-wide host link and turns each framed host transaction into one internal action: a register read, a posted register write, or a memory-block write. A single command byte, presented with the start strobe, selects both the kind of action and its target (a register number or a memory bank). Payload bytes are counted until the end strobe. The block then drives the matching back-end port and gives one accept/reject verdict per transaction.

Register reads wait on a request/acknowledge port and return the 16-bit value as a byte stream, high byte first, padded with zeros when more bytes are requested. Register writes pack up to two payload bytes into a 16-bit word and are issued without waiting. Memory-block writes forward the payload bytes to the memory side as they arrive, then hold a finish request until the memory side acknowledges with a pass/fail flag. While a read or a memory write is outstanding, the block drops its ready output and ignores any new start strobe.

Top module: `cbad_access_decoder`

## Requirements
- R1: A command byte with bit 7 set is a register access; bits 6:0 of the command appear unchanged on `rrd_addr` (read) or `rwr_addr` (write).
- R2: A write whose command bits 7:6 are both 0 is a memory-block write to bank = command bits 5:0: `mem_begin` pulses with `mem_bank` before any data, each payload byte appears once on `mem_wvalid`/`mem_wdata` in arrival order, `mem_finish` with `mem_len` is held until `mem_ack`, and the status in the cycle after `mem_ack` carries `stat_ok` = `mem_ok`.
- R3: A write whose command bits 7:6 are 01 is rejected: one status pulse with `stat_ok`=0 in the cycle after the end strobe, and no back-end port is driven.
- R4: A read whose command bit 7 is 0 is rejected the same way, with no register read request and no response bytes.
- R5: A register read of N requested bytes returns exactly N bytes: byte 0 is value bits 15:8, byte 1 is bits 7:0, every further byte is 0x00; a one-byte read returns only the high byte; a zero-byte read returns no bytes and is accepted.
- R6: A register write with zero payload bytes produces no `rwr_valid` pulse and is accepted.
- R7: A one-byte register write writes {byte, 0x00}; a write of two or more bytes writes {first byte, second byte}, later bytes having no effect.
- R8: `rrd_req` stays high with a stable address until `rrd_ack`; it is low in the cycle after the acknowledge, and the first response byte appears in that same cycle.
- R9: A register write is posted: `rwr_valid` pulses in the cycle after the end strobe, together with an accepting status, and `host_ready` is high in that cycle.
- R10: Every transaction gives exactly one single-cycle `stat_valid` pulse: in the cycle after the end strobe for register writes and rejects, in the cycle after the last response byte for reads (after the acknowledge for zero-byte reads).
- R11: `host_ready` is low from the end strobe of a read or memory write until its status pulse; a start strobe while it is low is ignored, together with the payload and end strobe that follow it.
- R12: A payload byte presented in the same cycle as the end strobe is counted and used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ready | output | 1 | High when a new start strobe is accepted |
| frm_start | input | 1 | Start of transaction, qualifies `frm_cmd` and `frm_is_read` |
| frm_is_read | input | 1 | 1 = host read, 0 = host write |
| frm_cmd | input | 8 | Command byte |
| frm_end | input | 1 | End of transaction |
| pay_valid | input | 1 | Payload byte strobe (also counts requested bytes on reads) |
| pay_byte | input | 8 | Payload byte |
| stat_valid | output | 1 | Single-cycle status pulse |
| stat_ok | output | 1 | 1 = accepted, 0 = rejected; valid with `stat_valid` |
| rsp_valid | output | 1 | Read response byte strobe |
| rsp_byte | output | 8 | Read response byte |
| rrd_req | output | 1 | Register read request, held until acknowledge |
| rrd_addr | output | 7 | Register read address |
| rrd_ack | input | 1 | Register read acknowledge |
| rrd_data | input | 16 | Register read value, valid with `rrd_ack` |
| rwr_valid | output | 1 | Posted register write pulse |
| rwr_addr | output | 7 | Register write address |
| rwr_data | output | 16 | Register write value |
| mem_begin | output | 1 | Memory write opening pulse |
| mem_bank | output | 6 | Memory bank |
| mem_wvalid | output | 1 | Memory data byte strobe |
| mem_wdata | output | 8 | Memory data byte |
| mem_finish | output | 1 | Memory write completion request, held until acknowledge |
| mem_len | output | CNT_W | Memory payload byte count |
| mem_ack | input | 1 | Memory completion acknowledge |
| mem_ok | input | 1 | Memory write result, valid with `mem_ack` |

## Verification
The end strobe may arrive in the same cycle as the last payload byte, so byte capture and transaction close coincide; for a memory write this also makes the last forwarded data byte and the finish request appear in one cycle. The bench drives both framings (end strobe alone and end strobe merged with the last byte) for register writes, reads and memory writes. It judges the merged case by the packed write word, the number of response bytes and the reported memory length, all of which must include that final byte.

// File: rtl/cbad_pkg.sv
package cbad_pkg;

    localparam int CMD_W  = 8;
    localparam int REG_AW = 7;
    localparam int BANK_W = 6;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CL_RREAD  = 2'd0,
        CL_RWRITE = 2'd1,
        CL_MWRITE = 2'd2,
        CL_BAD    = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FRAME  = 3'd1,
        ST_RDWAIT = 3'd2,
        ST_STREAM = 3'd3,
        ST_MWAIT  = 3'd4
    } st_e;

    typedef struct packed {
        cls_e              cls;
        logic [REG_AW-1:0] tgt;
    } cmd_t;

    function automatic cmd_t classify(input logic [CMD_W-1:0] c, input logic rd);
        cmd_t r;
        r.tgt = c[REG_AW-1:0];
        if (c[7])
            r.cls = rd ? CL_RREAD : CL_RWRITE;
        else if (!rd && !c[6])
            r.cls = CL_MWRITE;
        else
            r.cls = CL_BAD;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] v,
                                                    input int unsigned idx);
        if (idx == 0)
            return v[WORD_W-1:BYTE_W];
        else if (idx == 1)
            return v[BYTE_W-1:0];
        else
            return '0;
    endfunction

endpackage

// File: rtl/cbad_cmd_decode.sv
module cbad_cmd_decode
    import cbad_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             is_read,
    output cmd_t             dec
);
    always_comb begin
        dec = classify(cmd, is_read);
    end
endmodule

// File: rtl/cbad_wr_packer.sv
module cbad_wr_packer
    import cbad_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [BYTE_W-1:0] din,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic [WORD_W-1:0] word_nxt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] hi_q, lo_q, hi_n, lo_n;

    always_comb begin
        cnt_nxt = cnt_q;
        hi_n    = hi_q;
        lo_n    = lo_q;
        if (take) begin
            if (cnt_q == '0)
                hi_n = din;
            if (cnt_q == ONE)
                lo_n = din;
            if (cnt_q != TOP)
                cnt_nxt = cnt_q + ONE;
        end
        word_nxt = {hi_n, lo_n};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            hi_q  <= hi_n;
            lo_q  <= lo_n;
        end
    end
endmodule

// File: rtl/cbad_rd_serializer.sv
module cbad_rd_serializer
    import cbad_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] value,
    input  logic [CNT_W-1:0]  len,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  idx_q;
    logic [WORD_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            rem_q     <= '0;
            idx_q     <= '0;
            val_q     <= '0;
        end else if (load && len != '0) begin
            out_valid <= 1'b1;
            out_byte  <= pick_byte(value, 0);
            idx_q     <= ONE;
            rem_q     <= len - ONE;
            val_q     <= value;
        end else if (out_valid) begin
            if (rem_q == '0) begin
                out_valid <= 1'b0;
                out_byte  <= '0;
            end else begin
                out_byte <= pick_byte(val_q, 32'(idx_q));
                idx_q    <= idx_q + ONE;
                rem_q    <= rem_q - ONE;
            end
        end
    end

    assign out_last = out_valid && (rem_q == '0);
endmodule

// File: rtl/cbad_access_decoder.sv
module cbad_access_decoder
    import cbad_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              host_ready,
    input  logic              frm_start,
    input  logic              frm_is_read,
    input  logic [7:0]        frm_cmd,
    input  logic              frm_end,
    input  logic              pay_valid,
    input  logic [7:0]        pay_byte,
    output logic              stat_valid,
    output logic              stat_ok,
    output logic              rsp_valid,
    output logic [7:0]        rsp_byte,
    output logic              rrd_req,
    output logic [6:0]        rrd_addr,
    input  logic              rrd_ack,
    input  logic [15:0]       rrd_data,
    output logic              rwr_valid,
    output logic [6:0]        rwr_addr,
    output logic [15:0]       rwr_data,
    output logic              mem_begin,
    output logic [5:0]        mem_bank,
    output logic              mem_wvalid,
    output logic [7:0]        mem_wdata,
    output logic              mem_finish,
    output logic [CNT_W-1:0]  mem_len,
    input  logic              mem_ack,
    input  logic              mem_ok
);
    st_e               st_q;
    cmd_t              cmd_q;
    cmd_t              dec;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [WORD_W-1:0] word_nxt;
    logic              in_frame, take, accept_start, ser_load, rsp_last;

    assign host_ready   = (st_q == ST_IDLE);
    assign in_frame     = (st_q == ST_FRAME);
    assign take         = in_frame && pay_valid;
    assign accept_start = host_ready && frm_start;
    assign ser_load     = (st_q == ST_RDWAIT) && rrd_ack;

    cbad_cmd_decode u_dec (
        .cmd     (frm_cmd),
        .is_read (frm_is_read),
        .dec     (dec)
    );

    cbad_wr_packer #(.CNT_W(CNT_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept_start),
        .take     (take),
        .din      (pay_byte),
        .cnt_nxt  (cnt_nxt),
        .word_nxt (word_nxt)
    );

    cbad_rd_serializer #(.CNT_W(CNT_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .value     (rrd_data),
        .len       (len_q),
        .out_valid (rsp_valid),
        .out_byte  (rsp_byte),
        .out_last  (rsp_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cmd_q      <= '0;
            len_q      <= '0;
            stat_valid <= 1'b0;
            stat_ok    <= 1'b0;
            rrd_req    <= 1'b0;
            rrd_addr   <= '0;
            rwr_valid  <= 1'b0;
            rwr_addr   <= '0;
            rwr_data   <= '0;
            mem_begin  <= 1'b0;
            mem_bank   <= '0;
            mem_wvalid <= 1'b0;
            mem_wdata  <= '0;
            mem_finish <= 1'b0;
            mem_len    <= '0;
        end else begin
            stat_valid <= 1'b0;
            rwr_valid  <= 1'b0;
            mem_begin  <= 1'b0;
            mem_wvalid <= take && (cmd_q.cls == CL_MWRITE);
            if (take)
                mem_wdata <= pay_byte;

            case (st_q)
                ST_IDLE: begin
                    if (frm_start) begin
                        cmd_q <= dec;
                        st_q  <= ST_FRAME;
                        if (dec.cls == CL_MWRITE) begin
                            mem_begin <= 1'b1;
                            mem_bank  <= dec.tgt[BANK_W-1:0];
                        end
                    end
                end
                ST_FRAME: begin
                    if (frm_end) begin
                        case (cmd_q.cls)
                            CL_RREAD: begin
                                rrd_req  <= 1'b1;
                                rrd_addr <= cmd_q.tgt;
                                len_q    <= cnt_nxt;
                                st_q     <= ST_RDWAIT;
                            end
                            CL_RWRITE: begin
                                rwr_valid  <= (cnt_nxt != '0);
                                rwr_addr   <= cmd_q.tgt;
                                rwr_data   <= word_nxt;
                                stat_valid <= 1'b1;
                                stat_ok    <= 1'b1;
                                st_q       <= ST_IDLE;
                            end
                            CL_MWRITE: begin
                                mem_finish <= 1'b1;
                                mem_len    <= cnt_nxt;
                                st_q       <= ST_MWAIT;
                            end
                            default: begin
                                stat_valid <= 1'b1;
                                stat_ok    <= 1'b0;
                                st_q       <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_RDWAIT: begin
                    if (rrd_ack) begin
                        rrd_req <= 1'b0;
                        if (len_q == '0) begin
                            stat_valid <= 1'b1;
                            stat_ok    <= 1'b1;
                            st_q       <= ST_IDLE;
                        end else begin
                            st_q <= ST_STREAM;
                        end
                    end
                end
                ST_STREAM: begin
                    if (rsp_last) begin
                        stat_valid <= 1'b1;
                        stat_ok    <= 1'b1;
                        st_q       <= ST_IDLE;
                    end
                end
                ST_MWAIT: begin
                    if (mem_ack) begin
                        mem_finish <= 1'b0;
                        stat_valid <= 1'b1;
                        stat_ok    <= mem_ok;
                        st_q       <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cbad_access_checker.sv
module cbad_access_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             host_ready,
    input logic             stat_valid,
    input logic             stat_ok,
    input logic             rsp_valid,
    input logic [7:0]       rsp_byte,
    input logic             rrd_req,
    input logic [6:0]       rrd_addr,
    input logic             rrd_ack,
    input logic             rwr_valid,
    input logic             mem_finish,
    input logic [CNT_W-1:0] mem_len,
    input logic [5:0]       mem_bank,
    input logic             mem_ack
);
    assert_stat_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rrd_req && !rrd_ack) |=> (rrd_req && $stable(rrd_addr)));

    assert_read_release_R8: assert property (@(posedge clk) disable iff (rst)
        (rrd_req && rrd_ack) |=> !rrd_req);

    assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
        (rrd_req || rsp_valid || mem_finish) |-> !host_ready);

    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_finish && !mem_ack) |=> (mem_finish && $stable(mem_len) && $stable(mem_bank)));

    assert_posted_R9: assert property (@(posedge clk) disable iff (rst)
        rwr_valid |-> (stat_valid && stat_ok && host_ready));

    assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && !stat_ok) |-> (!rwr_valid && !rsp_valid));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(rsp_valid) && $past(rsp_valid, 2)) |-> (rsp_byte == 8'h00));
endmodule

bind cbad_access_decoder cbad_access_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ready (host_ready),
    .stat_valid (stat_valid),
    .stat_ok    (stat_ok),
    .rsp_valid  (rsp_valid),
    .rsp_byte   (rsp_byte),
    .rrd_req    (rrd_req),
    .rrd_addr   (rrd_addr),
    .rrd_ack    (rrd_ack),
    .rwr_valid  (rwr_valid),
    .mem_finish (mem_finish),
    .mem_len    (mem_len),
    .mem_bank   (mem_bank),
    .mem_ack    (mem_ack)
);

// File: tb/sim_cbad_access_decoder.sv
`timescale 1ns/1ps
module sim_cbad_access_decoder;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             host_ready, frm_start, frm_is_read, frm_end, pay_valid;
    logic [7:0]       frm_cmd, pay_byte;
    logic             stat_valid, stat_ok, rsp_valid;
    logic [7:0]       rsp_byte;
    logic             rrd_req, rrd_ack;
    logic [6:0]       rrd_addr;
    logic [15:0]      rrd_data;
    logic             rwr_valid;
    logic [6:0]       rwr_addr;
    logic [15:0]      rwr_data;
    logic             mem_begin, mem_wvalid, mem_finish, mem_ack, mem_ok;
    logic [5:0]       mem_bank;
    logic [7:0]       mem_wdata;
    logic [CNT_W-1:0] mem_len;

    cbad_access_decoder #(.CNT_W(CNT_W)) u0 (.*);

    typedef struct {
        logic [31:0] v;
        string       tag;
    } item_t;

    item_t q_stat[$], q_rsp[$], q_rwr[$], q_bank[$], q_mdat[$], q_mlen[$];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int rd_lat = 2;
    int mem_lat = 3;
    bit mem_ok_plan = 1'b1;
    logic [6:0] exp_raddr = '0;
    int exp_rd_n = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rv(input logic [6:0] a);
        return {1'b1, a, 8'h5A ^ {1'b0, a}};
    endfunction

    task automatic pop_cmp(inout item_t q[$], input string what, input logic [31:0] act);
        item_t it;
        if (q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL unexpected %s: actual %0h expected none", what, act);
        end else begin
            it = q.pop_front();
            chk(it.tag, act, it.v);
        end
    endtask

    // monitor
    initial begin
        logic fin_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (stat_valid) pop_cmp(q_stat, "status", {31'b0, stat_ok});
                if (rsp_valid)  pop_cmp(q_rsp, "rsp byte", {24'b0, rsp_byte});
                if (rwr_valid)  pop_cmp(q_rwr, "reg write", {9'b0, rwr_addr, rwr_data});
                if (mem_begin)  pop_cmp(q_bank, "mem bank", {26'b0, mem_bank});
                if (mem_wvalid) pop_cmp(q_mdat, "mem byte", {24'b0, mem_wdata});
                if (mem_finish && !fin_prev) pop_cmp(q_mlen, "mem len", {24'b0, mem_len});
                fin_prev = mem_finish;
            end
        end
    end

    // register read responder
    initial begin
        int w = 0;
        rrd_ack = 1'b0;
        rrd_data = '0;
        forever begin
            @(negedge clk);
            if (rrd_ack) begin
                rrd_ack = 1'b0;
                w = 0;
                chk("R8 req released", {31'b0, rrd_req}, 32'd0);
                chk("R8 first byte after ack", {31'b0, rsp_valid}, {31'b0, exp_rd_n > 0});
            end else if (rrd_req) begin
                w++;
                chk("R11 ready low during read", {31'b0, host_ready}, 32'd0);
                if (w >= rd_lat) begin
                    chk("R1 read address", {25'b0, rrd_addr}, {25'b0, exp_raddr});
                    rrd_ack  = 1'b1;
                    rrd_data = rv(rrd_addr);
                end
            end
        end
    end

    // memory responder
    initial begin
        int w = 0;
        mem_ack = 1'b0;
        mem_ok = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                w = 0;
            end else if (mem_finish) begin
                w++;
                if (w >= mem_lat) begin
                    chk("R11 ready low during mem write", {31'b0, host_ready}, 32'd0);
                    mem_ack = 1'b1;
                    mem_ok  = mem_ok_plan;
                end
            end
        end
    end

    function automatic logic [7:0] pb(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    // driver: pushes expectations, then drives one framed transaction
    task automatic txn(input logic [7:0] cmd, input bit rd, input int n,
                       input logic [7:0] seed, input bit merge_end, input bit mok);
        int cls;
        logic [15:0] w;
        item_t it;
        while (!host_ready) @(negedge clk);
        if (cmd[7]) cls = rd ? 0 : 1;
        else if (!rd && !cmd[6]) cls = 2;
        else cls = 3;
        mem_ok_plan = mok;
        case (cls)
            0: begin
                exp_raddr = cmd[6:0];
                exp_rd_n = n;
                for (int i = 0; i < n; i++) begin
                    w = rv(cmd[6:0]);
                    it.v = (i == 0) ? {24'b0, w[15:8]} : (i == 1) ? {24'b0, w[7:0]} : 32'd0;
                    it.tag = (n == 1) ? "R5 one-byte read" : "R5 read byte";
                    q_rsp.push_back(it);
                end
                it.v = 1; it.tag = "R10 read status"; q_stat.push_back(it);
            end
            1: begin
                if (n > 0) begin
                    w = (n == 1) ? {pb(seed, 0), 8'h00} : {pb(seed, 0), pb(seed, 1)};
                    it.v = {9'b0, cmd[6:0], w};
                    it.tag = merge_end ? "R12 R7 write word" : "R1 R7 write word";
                    q_rwr.push_back(it);
                end
                it.v = 1; it.tag = (n == 0) ? "R6 empty write status" : "R9 write status";
                q_stat.push_back(it);
            end
            2: begin
                it.v = {26'b0, cmd[5:0]}; it.tag = "R2 bank"; q_bank.push_back(it);
                for (int i = 0; i < n; i++) begin
                    it.v = {24'b0, pb(seed, i)}; it.tag = "R2 mem byte"; q_mdat.push_back(it);
                end
                it.v = n; it.tag = merge_end ? "R12 mem length" : "R2 mem length";
                q_mlen.push_back(it);
                it.v = {31'b0, mok}; it.tag = "R2 mem status"; q_stat.push_back(it);
            end
            default: begin
                it.v = 0; it.tag = rd ? "R4 read reject" : "R3 write reject";
                q_stat.push_back(it);
            end
        endcase
        frm_start = 1'b1; frm_cmd = cmd; frm_is_read = rd;
        @(negedge clk);
        frm_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pay_valid = 1'b1;
            pay_byte  = pb(seed, i);
            if (merge_end && i == n - 1) frm_end = 1'b1;
            @(negedge clk);
            pay_valid = 1'b0;
            frm_end   = 1'b0;
        end
        if (!merge_end || n == 0) begin
            frm_end = 1'b1;
            @(negedge clk);
            frm_end = 1'b0;
        end
        if (cls == 1 || cls == 3) begin
            chk(cls == 1 ? "R9 status after end" : "R10 reject status after end",
                {31'b0, stat_valid}, 32'd1);
            chk("R9 ready after posted write", {31'b0, host_ready}, 32'd1);
            chk("R6 write pulse only with bytes", {31'b0, rwr_valid},
                {31'b0, (cls == 1) && (n > 0)});
        end else begin
            chk("R11 ready low after end", {31'b0, host_ready}, 32'd0);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        frm_start = 0; frm_is_read = 0; frm_cmd = 0; frm_end = 0;
        pay_valid = 0; pay_byte = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset ready", {31'b0, host_ready}, 32'd1);
        chk("R10 reset status", {31'b0, stat_valid}, 32'd0);
        chk("R8 reset request", {31'b0, rrd_req}, 32'd0);
        chk("R2 reset finish", {31'b0, mem_finish}, 32'd0);

        // register writes (R7, R6, R12)
        txn(8'h85, 0, 2, 8'h11, 0, 1);
        txn(8'hC3, 0, 3, 8'h21, 1, 1);
        txn(8'hFF, 0, 1, 8'h31, 0, 1);
        txn(8'h80, 0, 0, 8'h00, 0, 1);
        txn(8'h9A, 0, 2, 8'h41, 1, 1);
        // register reads (R5, R8)
        txn(8'h81, 1, 2, 8'h00, 0, 1);
        txn(8'hB7, 1, 1, 8'h00, 1, 1);
        rd_lat = 4;
        txn(8'hFE, 1, 5, 8'h00, 0, 1);
        txn(8'hA0, 1, 0, 8'h00, 0, 1);
        rd_lat = 1;
        txn(8'h8C, 1, 3, 8'h00, 1, 1);
        // memory writes (R2, R12)
        txn(8'h05, 0, 5, 8'h51, 0, 1);
        txn(8'h3F, 0, 3, 8'h61, 1, 0);
        txn(8'h00, 0, 4, 8'h71, 1, 1);
        // rejects (R3, R4)
        txn(8'h45, 0, 2, 8'h81, 0, 1);
        txn(8'h7F, 0, 0, 8'h00, 0, 1);
        txn(8'h12, 1, 2, 8'h00, 0, 1);
        txn(8'h45, 1, 1, 8'h00, 1, 1);

        // R11: start while a read is outstanding must be ignored
        rd_lat = 8;
        txn(8'h91, 1, 2, 8'h00, 0, 1);
        frm_start = 1'b1; frm_cmd = 8'h85; frm_is_read = 1'b0;
        @(negedge clk);
        frm_start = 1'b0; pay_valid = 1'b1; pay_byte = 8'hEE; frm_end = 1'b1;
        @(negedge clk);
        pay_valid = 1'b0; frm_end = 1'b0;
        chk("R11 ready still low", {31'b0, host_ready}, 32'd0);
        rd_lat = 2;
        // R11: same during a memory write
        mem_lat = 6;
        txn(8'h2A, 0, 2, 8'h91, 0, 1);
        frm_start = 1'b1; frm_cmd = 8'h40; frm_is_read = 1'b0;
        @(negedge clk);
        frm_start = 1'b0; frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
        mem_lat = 3;
        txn(8'h86, 0, 2, 8'hA1, 0, 1);

        repeat (30) @(negedge clk);
        chk("R10 all statuses seen", q_stat.size(), 0);
        chk("R5 all read bytes seen", q_rsp.size(), 0);
        chk("R7 all writes seen", q_rwr.size(), 0);
        chk("R2 all mem items seen", q_bank.size() + q_mdat.size() + q_mlen.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule